// File: doc/BRIEF.md
# Stereo Serial Audio DAC Transmitter

This block drives the serial input of a stereo audio DAC. It runs entirely on a free-running bit clock supplied from outside (nominally 32 bit periods per 44.1 kHz sample frame, 1.4112 MHz). Every frame carries two 16-bit words, left first and then right, each sent most significant bit first. A channel clock is low for the left word and high for the right word, so it changes once per word. A one-bit frame-sync pulse marks the first bit of each frame. An active-low attenuation line, driven from a request input, asks the DAC for a 12 dB cut.

Samples arrive on a valid/ready pair in the bit-clock domain. Once per word, during that word's last bit, the block raises a one-cycle transmit request, with ready high in the same cycle, and takes one sample into a holding register. A companion flag tells the source whether the word it is supplying belongs to the left channel. The shift register and the holding register form a two-deep pipeline, so a word taken during word N goes out as word N+2, which is on the same channel. Both registers are primed with zero during a one-cycle start-up state, so the first frame after reset is silent. If the source has no sample when one is taken, a zero word is sent instead and a sticky underflow flag is set. A write-one pulse clears the flag.

The sequencer has three states. ST_PRIME is the reset state; it loads zeros into both registers and moves to ST_LEFT on the next edge. ST_LEFT moves to ST_RIGHT after the last bit of the left word. ST_RIGHT moves back to ST_LEFT after the last bit of the right word. No other transitions exist.

Top module: `stdac_tx`

## Requirements
- R1: While reset is held and after release, the block sits in ST_PRIME for one clock, with sdata, chan_clk, fsync and tx_req low. The first two words sent after reset (one full frame) are all zeros.
- R2: Words are 16 bits, sent MSB first, one bit per clock. chan_clk is 0 for the left word and 1 for the right word, and it changes only at a word boundary.
- R3: fsync is 1 only during bit 0 (the MSB) of every left word.
- R4: tx_req and s_ready are 1 together for exactly one clock, during the last bit (bit index 15) of every word. req_left is 1 in that clock when the current word is a left word, and 0 otherwise.
- R5: A word accepted (s_valid and s_ready both 1 at a clock edge) during word N is transmitted as word N+2, on the same channel as word N.
- R6: If s_valid is 0 when s_ready is 1, the word sent two words later is all zeros, and err_flag is 1 from the next clock on.
- R7: err_flag stays set until a clock edge at which err_clr is 1 and no new underflow occurs. When an underflow and err_clr coincide, the flag stays set.
- R8: atten_n equals the inverse of atten_on as sampled at the previous clock edge, and it is 1 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Free-running bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample available |
| s_data | input | 16 | Sample word |
| s_ready | output | 1 | Sample taken at this edge if valid |
| req_left | output | 1 | Requested sample is for the left channel |
| tx_req | output | 1 | One-cycle transmit-data request per word |
| atten_on | input | 1 | Request 12 dB attenuation |
| err_clr | input | 1 | Write-one clear of the underflow flag |
| sdata | output | 1 | Serial data to the DAC |
| chan_clk | output | 1 | Channel clock, 0 = left, 1 = right |
| fsync | output | 1 | One-bit frame sync on the first left bit |
| atten_n | output | 1 | Active-low attenuation control |
| err_flag | output | 1 | Sticky underflow flag |

## Verification
A wrong sequencer state or bit count shows up within one clock as a misplaced fsync, tx_req or chan_clk edge, because all three are decoded directly from that state. A fault in the holding or shift path, such as an off-by-one in the two-word pipeline, a missing zero prime or a lost underflow substitution, appears on sdata at most two words (32 clocks) later, as a wrong bit against the word the bench expects. The bench keeps a queue of pending words, driven only by what it offered at each request. It compares every output on every clock, so a fault is reported in the first cycle it becomes visible.

// File: rtl/stdac_pkg.sv
package stdac_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } stdac_state_e;
endpackage

// File: rtl/stdac_seq.sv
module stdac_seq
    import stdac_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output stdac_state_e     state,
    output logic [BIT_W-1:0] bit_idx,
    output logic             last_bit
);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    stdac_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME: state_nx = ST_LEFT;
            ST_LEFT:  if (bit_idx == LAST_IDX) state_nx = ST_RIGHT;
            ST_RIGHT: if (bit_idx == LAST_IDX) state_nx = ST_LEFT;
            default:  state_nx = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PRIME;
            bit_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_PRIME || bit_idx == LAST_IDX)
                bit_idx <= '0;
            else
                bit_idx <= bit_idx + 1'b1;
        end
    end

    assign last_bit = (state != ST_PRIME) && (bit_idx == LAST_IDX);

    AST_PRIME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PRIME |=> state == ST_LEFT && bit_idx == '0); // R1
    AST_LEFT_THEN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEFT && last_bit) |=> state == ST_RIGHT); // R2
    AST_RIGHT_THEN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RIGHT && last_bit) |=> state == ST_LEFT); // R2
endmodule

// File: rtl/stdac_shift.sv
module stdac_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_zero,
    input  logic              last_bit,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              ser_bit,
    output logic              underflow
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            hold  <= '0;
        end else if (load_zero) begin
            shreg <= '0;
            hold  <= '0;
        end else if (last_bit) begin
            shreg <= hold;
            hold  <= in_valid ? in_data : '0;
        end else begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    assign ser_bit   = shreg[WORD_W-1];
    assign underflow = last_bit && !in_valid;

    AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        load_zero |=> !ser_bit); // R1
    AST_STARVED_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !in_valid) |=> hold == '0); // R6
endmodule

// File: rtl/stdac_tx.sv
module stdac_tx
    import stdac_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    output logic              req_left,
    output logic              tx_req,
    input  logic              atten_on,
    input  logic              err_clr,
    output logic              sdata,
    output logic              chan_clk,
    output logic              fsync,
    output logic              atten_n,
    output logic              err_flag
);
    localparam int BIT_W = $clog2(WORD_W);

    stdac_state_e     state;
    logic [BIT_W-1:0] bit_idx;
    logic             last_bit;
    logic             ser_bit;
    logic             underflow;
    logic             err_q;
    logic             atten_q;

    stdac_seq #(.WORD_W(WORD_W)) i_seq (
        .clk      (bclk),
        .rst_n    (rst_n),
        .state    (state),
        .bit_idx  (bit_idx),
        .last_bit (last_bit)
    );

    stdac_shift #(.WORD_W(WORD_W)) i_shift (
        .clk       (bclk),
        .rst_n     (rst_n),
        .load_zero (state == ST_PRIME),
        .last_bit  (last_bit),
        .in_valid  (s_valid),
        .in_data   (s_data),
        .ser_bit   (ser_bit),
        .underflow (underflow)
    );

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            atten_q <= 1'b0;
        end else begin
            atten_q <= atten_on;
            if (underflow)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        chan_clk = (state == ST_RIGHT);
        fsync    = (state == ST_LEFT) && (bit_idx == '0);
        tx_req   = last_bit;
        s_ready  = last_bit;
        req_left = last_bit && (state == ST_LEFT);
        sdata    = ser_bit;
        atten_n  = !atten_q;
        err_flag = err_q;
    end

    AST_REQ_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
        tx_req |=> !tx_req); // R4
    AST_FSYNC_ON_LEFT: assert property (@(posedge bclk) disable iff (!rst_n)
        fsync |-> !chan_clk && !tx_req); // R3
    AST_CHAN_AT_BOUNDARY: assert property (@(posedge bclk) disable iff (!rst_n)
        !tx_req |=> $stable(chan_clk)); // R2
    AST_UNDERFLOW_FLAGS: assert property (@(posedge bclk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> err_flag); // R6
    AST_ERR_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R7
    AST_ATTEN_FOLLOW: assert property (@(posedge bclk) disable iff (!rst_n)
        1'b1 |=> atten_n == !$past(atten_on)); // R8
endmodule

// File: tb/test_stdac_tx.sv
module test_stdac_tx;
    localparam int CLK_PERIOD = 708;
    localparam int W = 16;

    logic         bclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_valid = 1'b0;
    logic [W-1:0] s_data = '0;
    logic         atten_on = 1'b0;
    logic         err_clr = 1'b0;
    logic         s_ready, req_left, tx_req, sdata, chan_clk, fsync, atten_n, err_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    stdac_tx #(.WORD_W(W)) i_stdac_tx (
        .bclk(bclk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .req_left(req_left), .tx_req(tx_req),
        .atten_on(atten_on), .err_clr(err_clr), .sdata(sdata),
        .chan_clk(chan_clk), .fsync(fsync), .atten_n(atten_n), .err_flag(err_flag)
    );

    // Reference model: mbit = -1 means start-up state; word queue holds
    // the word on the wire (front) and the next one.
    int           mbit = -1;
    int           mword = 0;
    logic [W-1:0] q_word[$];
    int           q_tag[$];
    bit           merr = 1'b0;
    bit           matt = 1'b0;

    always @(posedge bclk) begin
        if (!rst_n) begin
            mbit = -1; mword = 0; merr = 1'b0; matt = 1'b0;
            q_word = {}; q_tag = {};
        end else begin
            matt = atten_on;
            if (mbit == -1) begin
                mbit = 0; mword = 0;
                q_word = {16'h0000, 16'h0000};
                q_tag  = {1, 1};   // R1 primed zero words
            end else if (mbit == W-1) begin
                void'(q_word.pop_front());
                void'(q_tag.pop_front());
                if (s_valid) begin
                    q_word.push_back(s_data); q_tag.push_back(5);  // R5
                end else begin
                    q_word.push_back('0); q_tag.push_back(6);      // R6
                end
                if (!s_valid) merr = 1'b1;
                else if (err_clr) merr = 1'b0;
                mbit = 0; mword++;
            end else begin
                mbit++;
                if (err_clr) merr = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit e_sd, e_ch, e_fs, e_rq, e_lf;
        string sreq;
        if (mbit < 0) begin
            e_sd = 0; e_ch = 0; e_fs = 0; e_rq = 0; e_lf = 0; sreq = "R1 sdata";
        end else begin
            e_ch = mword[0];
            e_sd = q_word[0][W-1-mbit];
            e_fs = (e_ch == 0) && (mbit == 0);
            e_rq = (mbit == W-1);
            e_lf = e_rq && (e_ch == 0);
            sreq = (q_tag[0] == 1) ? "R1 sdata" : (q_tag[0] == 6) ? "R6 sdata" : "R2/R5 sdata";
        end
        chk(sdata == e_sd, sreq, sdata, e_sd);
        chk(chan_clk == e_ch, "R2 chan_clk", chan_clk, e_ch);
        chk(fsync == e_fs, "R3 fsync", fsync, e_fs);
        chk(tx_req == e_rq, "R4 tx_req", tx_req, e_rq);
        chk(s_ready == e_rq, "R4 s_ready", s_ready, e_rq);
        chk(req_left == e_lf, "R4 req_left", req_left, e_lf);
        chk(err_flag == merr, "R7 err_flag", err_flag, merr);
        chk(atten_n == !matt, "R8 atten_n", atten_n, !matt);
    endtask

    initial begin
        logic [W-1:0] lfsr = 16'hACE1;
        repeat (3) @(negedge bclk);
        check_all();  // R1 reset state
        rst_n = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            @(negedge bclk);
            check_all();
            lfsr = {lfsr[W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (n % 5)
                0: s_data = lfsr;
                1: s_data = 16'h8001;
                2: s_data = 16'hFFFF;
                3: s_data = 16'h0000;
                default: s_data = 16'h5A5A ^ n[15:0];
            endcase
            // underflow windows (R6), clear pulses (R7), overlapping clear
            s_valid  = !((n > 700 && n < 1000 && ((n / 16) % 3 == 0)) ||
                         (n > 1500 && n < 1700));
            err_clr  = (n == 1200) || (n > 1550 && n < 1650) || (n == 1800);
            atten_on = ((n / 37) % 2 == 1);  // R8
            if (n == 2200) rst_n = 1'b0;
            if (n == 2205) rst_n = 1'b1;
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule